// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit for a multicycle RISC datapath that shares one memory and one ALU across the steps of each instruction. It is a Moore machine with ten one-cycle states. Each instruction starts with a common fetch step and a common decode step. The controller then branches on the opcode from the instruction register into a short per-class tail, and every tail ends by going back to fetch. The five supported classes are word load, word store, register-format ALU operation, branch-if-equal and jump.

The outputs depend only on the current state. They drive every strobe and multiplexer select in the datapath: the memory read and write, the instruction-register load, the unconditional and conditional PC loads, the register-file write, the destination-register select, the write-back source, the memory address source, both ALU operand selects, the ALU operation class and the PC source. Any output that a state does not name is held at 0. Because of this, a datapath built around the block sees a fixed, known value on every control line in every cycle.

Top module: `mcController`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after a clock edge that samples `rst` high, the outputs show the fetch pattern. This holds even if an instruction was part way through.
- R2: The fetch pattern sets `memRead`=1, `irWrite`=1, `pcWrite`=1, `addrIsData`=0, `aluSrcA`=0 (PC), `aluSrcB`=2'b01 (constant 4), `aluOp`=2'b00 (add) and `pcSrc`=2'b00 (ALU output), with all other outputs 0. The decode pattern always follows it.
- R3: The decode pattern sets `aluSrcA`=0, `aluSrcB`=2'b11 (offset shifted left by two) and `aluOp`=2'b00, with every other output 0.
- R4: Opcode encodings are 6'h23 load, 6'h2B store, 6'h00 register format, 6'h04 branch-equal and 6'h02 jump. The opcode is sampled only when leaving decode and when leaving the address step.
- R5: The address pattern, used by load and store after decode, sets `aluSrcA`=1, `aluSrcB`=2'b10 (sign-extended offset) and `aluOp`=2'b00, with all other outputs 0.
- R6: A load runs fetch, decode, address, read and write-back, which is 5 cycles. Read sets `memRead`=1 and `addrIsData`=1. Write-back sets `regWrite`=1, `memToReg`=1 and `regDstRd`=0.
- R7: A store runs fetch, decode, address and write, which is 4 cycles. Write sets `memWrite`=1 and `addrIsData`=1.
- R8: A register operation runs fetch, decode, execute and write-back, which is 4 cycles. Execute sets `aluSrcA`=1, `aluSrcB`=2'b00 and `aluOp`=2'b10 (function field). Write-back sets `regWrite`=1, `regDstRd`=1 and `memToReg`=0.
- R9: A branch runs fetch, decode and compare, which is 3 cycles. Compare sets `aluSrcA`=1, `aluSrcB`=2'b00, `aluOp`=2'b01 (subtract), `pcWriteCond`=1 and `pcSrc`=2'b01 (saved target).
- R10: A jump runs fetch, decode and jump, which is 3 cycles. Jump sets `pcWrite`=1 and `pcSrc`=2'b10 (concatenated jump address).
- R11: Any opcode not listed in R4 that is seen at decode sends the controller straight back to fetch, which is 2 cycles.
- R12: `memRead` and `memWrite` are never high together. Every final step of an instruction is followed by fetch.
- R13: A change of opcode during fetch, read, execute or any write-back step has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| irWrite | output | 1 | Instruction register load |
| pcWrite | output | 1 | Unconditional PC load |
| pcWriteCond | output | 1 | PC load qualified by the ALU zero flag |
| regWrite | output | 1 | Register file write |
| regDstRd | output | 1 | Destination is rd (1) or rt (0) |
| memToReg | output | 1 | Write-back from memory data (1) or ALU result (0) |
| addrIsData | output | 1 | Memory address from ALU result (1) or PC (0) |
| aluSrcA | output | 1 | ALU input A: register A (1) or PC (0) |
| aluSrcB | output | 2 | ALU input B: B, constant 4, offset, or offset shifted |
| aluOp | output | 2 | ALU class: add, subtract, or function field |
| pcSrc | output | 2 | PC source: ALU output, saved target, or jump address |

## Verification
The bench walks every instruction class and checks the full output word in each cycle, so a state with a stray strobe or a wrong select is caught. It also checks that the next fetch arrives exactly after 5, 4, 4, 3 or 3 cycles, which exposes a missing or extra step. An unknown opcode must fall back to fetch after decode; a design that treats it as a register operation would run four cycles instead. The bench changes the opcode in the middle of load and register sequences to catch a design that re-decodes outside its two branch points. It also asserts reset in the middle of a load, which exposes a reset that waits for the instruction to finish.

// File: rtl/mcCtrl_pkg.sv
package mcCtrl_pkg;

  localparam int OPC_W = 6;
  localparam int ST_W  = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_MEMRD   = 4'd3,
    ST_LDWB    = 4'd4,
    ST_MEMWR   = 4'd5,
    ST_EXEC    = 4'd6,
    ST_ALUWB   = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9
  } mcState_e;

  typedef struct packed {
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       pcWrite;
    logic       pcWriteCond;
    logic       regWrite;
    logic       regDstRd;
    logic       memToReg;
    logic       addrIsData;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] aluOp;
    logic [1:0] pcSrc;
  } ctrlStrobes_t;

endpackage

// File: rtl/mcSequencer.sv
module mcSequencer
  import mcCtrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output mcState_e         stateNow
);

  mcState_e stateNext;

  always_comb begin
    stateNext = ST_FETCH;
    case (stateNow)
      ST_FETCH:  stateNext = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_LOAD, OPC_STORE: stateNext = ST_ADDR;
          OPC_RTYPE:           stateNext = ST_EXEC;
          OPC_BEQ:             stateNext = ST_BRANCH;
          OPC_JUMP:            stateNext = ST_JUMP;
          default:             stateNext = ST_FETCH;
        endcase
      end
      ST_ADDR:   stateNext = (opcode == OPC_STORE) ? ST_MEMWR : ST_MEMRD;
      ST_MEMRD:  stateNext = ST_LDWB;
      ST_EXEC:   stateNext = ST_ALUWB;
      default:   stateNext = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateNow <= ST_FETCH;
    else     stateNow <= stateNext;
  end

endmodule

// File: rtl/mcStrobeDecode.sv
module mcStrobeDecode
  import mcCtrl_pkg::*;
(
  input  mcState_e     stateNow,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    case (stateNow)
      ST_FETCH: begin
        strobes.memRead = 1'b1;
        strobes.irWrite = 1'b1;
        strobes.pcWrite = 1'b1;
        strobes.aluSrcB = 2'b01;
      end
      ST_DECODE: strobes.aluSrcB = 2'b11;
      ST_ADDR: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = 2'b10;
      end
      ST_MEMRD: begin
        strobes.memRead    = 1'b1;
        strobes.addrIsData = 1'b1;
      end
      ST_LDWB: begin
        strobes.regWrite = 1'b1;
        strobes.memToReg = 1'b1;
      end
      ST_MEMWR: begin
        strobes.memWrite   = 1'b1;
        strobes.addrIsData = 1'b1;
      end
      ST_EXEC: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluOp   = 2'b10;
      end
      ST_ALUWB: begin
        strobes.regWrite = 1'b1;
        strobes.regDstRd = 1'b1;
      end
      ST_BRANCH: begin
        strobes.aluSrcA     = 1'b1;
        strobes.aluOp       = 2'b01;
        strobes.pcWriteCond = 1'b1;
        strobes.pcSrc       = 2'b01;
      end
      ST_JUMP: begin
        strobes.pcWrite = 1'b1;
        strobes.pcSrc   = 2'b10;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mcController.sv
module mcController
  import mcCtrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             memRead,
  output logic             memWrite,
  output logic             irWrite,
  output logic             pcWrite,
  output logic             pcWriteCond,
  output logic             regWrite,
  output logic             regDstRd,
  output logic             memToReg,
  output logic             addrIsData,
  output logic             aluSrcA,
  output logic [1:0]       aluSrcB,
  output logic [1:0]       aluOp,
  output logic [1:0]       pcSrc
);

  mcState_e     stateNow;
  ctrlStrobes_t strobes;

  mcSequencer i_seq (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .stateNow (stateNow)
  );

  mcStrobeDecode i_dec (
    .stateNow (stateNow),
    .strobes  (strobes)
  );

  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign irWrite     = strobes.irWrite;
  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign regWrite    = strobes.regWrite;
  assign regDstRd    = strobes.regDstRd;
  assign memToReg    = strobes.memToReg;
  assign addrIsData  = strobes.addrIsData;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign aluOp       = strobes.aluOp;
  assign pcSrc       = strobes.pcSrc;

endmodule

// File: rtl/mcController_chk.sv
module mcController_chk (
  input logic       clk,
  input logic       rst,
  input logic       memRead,
  input logic       memWrite,
  input logic       irWrite,
  input logic       pcWrite,
  input logic       pcWriteCond,
  input logic       regWrite,
  input logic       memToReg,
  input logic       addrIsData,
  input logic [1:0] aluSrcB,
  input logic [1:0] pcSrc
);

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (aluSrcB == 2'b11 && !irWrite && !memRead));

  // R6
  read_then_ldwb_chk: assert property (@(posedge clk) disable iff (rst)
    (memRead && addrIsData) |=> (regWrite && memToReg));

  // R7
  store_done_chk: assert property (@(posedge clk) disable iff (rst)
    memWrite |=> irWrite);

  // R12
  writeback_done_chk: assert property (@(posedge clk) disable iff (rst)
    regWrite |=> irWrite);

  // R9
  branch_done_chk: assert property (@(posedge clk) disable iff (rst)
    pcWriteCond |=> irWrite);

  // R10
  jump_done_chk: assert property (@(posedge clk) disable iff (rst)
    (pcWrite && pcSrc == 2'b10) |=> irWrite);

  // R12
  no_mem_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

endmodule

bind mcController mcController_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .memRead     (memRead),
  .memWrite    (memWrite),
  .irWrite     (irWrite),
  .pcWrite     (pcWrite),
  .pcWriteCond (pcWriteCond),
  .regWrite    (regWrite),
  .memToReg    (memToReg),
  .addrIsData  (addrIsData),
  .aluSrcB     (aluSrcB),
  .pcSrc       (pcSrc)
);

// File: tb/test_mcController.sv
module test_mcController;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       memRead, memWrite, irWrite, pcWrite, pcWriteCond, regWrite;
  logic       regDstRd, memToReg, addrIsData, aluSrcA;
  logic [1:0] aluSrcB, aluOp, pcSrc;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  mcController i_mcController (
    .clk(clk), .rst(rst), .opcode(opcode),
    .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .regWrite(regWrite),
    .regDstRd(regDstRd), .memToReg(memToReg), .addrIsData(addrIsData),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp), .pcSrc(pcSrc)
  );

  // Output word: memRead memWrite irWrite pcWrite pcWriteCond regWrite
  //              regDstRd memToReg addrIsData aluSrcA aluSrcB aluOp pcSrc
  function automatic logic [15:0] expWord(int step);
    case (step)
      0: return 16'b1_0_1_1_0_0_0_0_0_0_01_00_00; // fetch
      1: return 16'b0_0_0_0_0_0_0_0_0_0_11_00_00; // decode
      2: return 16'b0_0_0_0_0_0_0_0_0_1_10_00_00; // address
      3: return 16'b1_0_0_0_0_0_0_0_1_0_00_00_00; // memory read
      4: return 16'b0_0_0_0_0_1_0_1_0_0_00_00_00; // load write-back
      5: return 16'b0_1_0_0_0_0_0_0_1_0_00_00_00; // memory write
      6: return 16'b0_0_0_0_0_0_0_0_0_1_00_10_00; // execute
      7: return 16'b0_0_0_0_0_1_1_0_0_0_00_00_00; // alu write-back
      8: return 16'b0_0_0_0_1_0_0_0_0_1_00_01_01; // branch
      9: return 16'b0_0_0_1_0_0_0_0_0_0_00_00_10; // jump
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic int expStep(logic [5:0] op, int idx);
    if (idx == 0) return 0;
    if (idx == 1) return 1;
    case (op)
      6'h23:   return (idx == 2) ? 2 : (idx == 3) ? 3 : 4;
      6'h2B:   return (idx == 2) ? 2 : 5;
      6'h00:   return (idx == 2) ? 6 : 7;
      6'h04:   return 8;
      6'h02:   return 9;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] actWord();
    return {memRead, memWrite, irWrite, pcWrite, pcWriteCond, regWrite,
            regDstRd, memToReg, addrIsData, aluSrcA, aluSrcB, aluOp, pcSrc};
  endfunction

  task automatic checkStep(int step, string tag);
    testsRun++;
    if (actWord() !== expWord(step)) begin
      testsFailed++;
      $display("FAIL %s: outputs %b expected %b (step %0d)", tag, actWord(),
               expWord(step), step);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {opcode, cycles}
  localparam logic [9:0] VEC [8] = '{
    {6'h23, 4'd5}, {6'h2B, 4'd4}, {6'h00, 4'd4}, {6'h04, 4'd3},
    {6'h02, 4'd3}, {6'h3F, 4'd2}, {6'h23, 4'd5}, {6'h01, 4'd2}
  };

  initial begin
    #(20 * 200000);
    testsFailed++;
    $display("FAIL watchdog: run did not end, actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkStep(0, "R1 reset gives fetch");
    rst = 1'b0;

    // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11: walk each class and count its cycles
    for (int v = 0; v < 8; v++) begin
      opcode = VEC[v][9:4];
      for (int s = 0; s < int'(VEC[v][3:0]); s++) begin
        checkStep(expStep(opcode, s), "R2-path class step");
        tick();
      end
      checkStep(0, "R12 cycle count ends at fetch");
    end

    // R13: opcode changed to jump while in memory read; load must finish
    opcode = 6'h23;
    tick(); tick(); tick();
    checkStep(3, "R6 load read state");
    opcode = 6'h02;
    tick();
    checkStep(4, "R13 opcode change in read ignored");
    tick();
    checkStep(0, "R13 returns to fetch");

    // R13: opcode changed during register execute
    opcode = 6'h00;
    tick(); tick();
    checkStep(6, "R8 execute state");
    opcode = 6'h2B;
    tick();
    checkStep(7, "R13 opcode change in execute ignored");
    tick();
    checkStep(0, "R13 back to fetch after alu write-back");

    // R13: opcode changed during fetch only matters at decode
    opcode = 6'h04;
    tick();
    opcode = 6'h02;
    checkStep(1, "R13 decode state");
    tick();
    checkStep(9, "R4 decode samples jump");
    tick();

    // R1: reset in the middle of a load
    opcode = 6'h23;
    tick(); tick(); tick();
    checkStep(3, "R6 load read before reset");
    rst = 1'b1;
    tick();
    checkStep(0, "R1 reset mid-instruction");
    rst = 1'b0;
    tick();
    checkStep(1, "R1 decode after reset");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule